// File: doc/BRIEF.md
# Four-Mode Timer/Counter

This block is a byte-wide timer/counter of the kind found beside a small 8-bit processor core. Two count registers, a low byte and a high byte, advance on a shared tick enable. Depending on a mode byte, the pair forms one of four structures: a 13-bit counter whose low byte acts as a 5-bit prescaler, a plain 16-bit counter, an 8-bit counter that reloads from the high byte, or two independent 8-bit counters. In split mode the high byte runs from a second run bit supplied from outside and sets a second overflow flag.

The count source is either the internal tick or rising edges on an external count pin. Each source is counted at most once per tick. An external gate pin can hold off counting. Both pins pass through two-flop synchronisers. Software reaches all four registers through a single write port and a combinational read port. The overflow flags stay set until software writes the control byte.

Top module: `timer_unit`

## Requirements
- R1: After reset, all four registers read 0 and `ovf_o` and `ovf2_o` are low.
- R2: The register addresses are: 0 for the low count, 1 for the high count, 2 for the mode byte and 3 for the control byte. In the mode byte, bits [1:0] hold the mode, bit 2 selects the external count source and bit 3 enables the gate. Unused mode bits read 0. In the control byte, bit 0 is the run bit, bit 1 is the overflow flag and bit 2 is the split-mode high-byte overflow flag. Unused control bits read 0.
- R3: Mode 0 (mode bits 00) is the 13-bit counter. On each count, the low byte increments. When the low byte's lower five bits come out as zero, the low byte is cleared and the high byte increments. A high-byte wrap from 0xFF sets the overflow flag.
- R4: Mode 1 (mode bits 01) is a 16-bit counter. The high byte increments when the low byte wraps from 0xFF. A high-byte wrap sets the overflow flag.
- R5: Mode 2 (mode bits 10) counts only the low byte. When the low byte wraps from 0xFF, it loads the high byte's value and the overflow flag is set. The high byte is unchanged.
- R6: Mode 3 (mode bits 11) splits the pair. The low byte is an 8-bit counter whose wrap sets the overflow flag. The high byte increments on every tick while `run2_i` is high, ignoring the gate and the run bit, and its wrap sets `ovf2_o`.
- R7: While the run bit is 0, the low byte never counts in any mode. In modes 0 to 2, the high byte also stays still.
- R8: With the gate enabled, the low byte counts only while the synchronised gate pin is high.
- R9: With the external source selected, one count is made per tick only if a rising edge of the count pin has been seen since the previous tick. Several edges between ticks give one count. With the tick held high, a rise applied between clock edges is counted at the third rising clock edge.
- R10: A write to the mode byte discards a count-pin edge that is pending.
- R11: An overflow flag stays set until software writes the control byte. If an overflow occurs in the same cycle as a control write, the flag is set.
- R12: A software write to a count register takes priority over that register's increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write register address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read register address |
| rd_data_o | output | 8 | Read data for the register at `rd_addr_i` |
| tick_i | input | 1 | Machine-cycle tick enable |
| cnt_pin_i | input | 1 | External count pin (asynchronous) |
| gate_pin_i | input | 1 | External gate pin (asynchronous) |
| run2_i | input | 1 | Second timer run bit, used for the high byte in split mode |
| ovf_o | output | 1 | Overflow flag |
| ovf2_o | output | 1 | Split-mode high-byte overflow flag |

## Verification
The hardest situation to reach is a count-pin edge that is held pending across idle ticks. The stimulus has to pulse the pin with the tick held low, so that the edge is stored rather than consumed. The bench then either ticks once to show exactly one count, or rewrites the mode byte first to show that the edge is discarded. The race between a software write and an increment in the same cycle is also set up directly: the write strobe and the tick are raised at the same falling clock edge, for a count register and for the control byte during an overflow.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    MODE_13    = 2'b00,
    MODE_16    = 2'b01,
    MODE_8R    = 2'b10,
    MODE_SPLIT = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_MODE = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;
endpackage

// File: rtl/timer_pin_sync.sv
module timer_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/timer_count_core.sv
module timer_count_core
  import timer_pkg::*;
#(
  parameter int W     = 8,
  parameter int PRE_W = 5
) (
  input  tmr_mode_e      mode_i,
  input  logic [W-1:0]   lo_i,
  input  logic [W-1:0]   hi_i,
  input  logic           inc_lo_i,
  input  logic           inc_hi_i,
  output logic [W-1:0]   lo_o,
  output logic [W-1:0]   hi_o,
  output logic           ovf_set_o,
  output logic           ovf2_set_o
);
  logic [W-1:0] lo_inc;
  logic [W-1:0] hi_inc;
  logic         lo_full;
  logic         hi_full;

  assign lo_inc  = lo_i + 1'b1;
  assign hi_inc  = hi_i + 1'b1;
  assign lo_full = (lo_i == '1);
  assign hi_full = (hi_i == '1);

  always_comb begin
    lo_o       = lo_i;
    hi_o       = hi_i;
    ovf_set_o  = 1'b0;
    ovf2_set_o = 1'b0;
    unique case (mode_i)
      MODE_13: if (inc_lo_i) begin
        if (lo_inc[PRE_W-1:0] == '0) begin
          lo_o      = '0;
          hi_o      = hi_inc;
          ovf_set_o = hi_full;
        end else begin
          lo_o = lo_inc;
        end
      end
      MODE_16: if (inc_lo_i) begin
        lo_o = lo_inc;
        if (lo_full) begin
          hi_o      = hi_inc;
          ovf_set_o = hi_full;
        end
      end
      MODE_8R: if (inc_lo_i) begin
        if (lo_full) begin
          lo_o      = hi_i;
          ovf_set_o = 1'b1;
        end else begin
          lo_o = lo_inc;
        end
      end
      MODE_SPLIT: begin
        if (inc_lo_i) begin
          lo_o      = lo_inc;
          ovf_set_o = lo_full;
        end
        if (inc_hi_i) begin
          hi_o       = hi_inc;
          ovf2_set_o = hi_full;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/timer_unit.sv
module timer_unit
  import timer_pkg::*;
#(
  parameter int W           = 8,
  parameter int PRE_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [1:0]   rd_addr_i,
  output logic [W-1:0] rd_data_o,
  input  logic         tick_i,
  input  logic         cnt_pin_i,
  input  logic         gate_pin_i,
  input  logic         run2_i,
  output logic         ovf_o,
  output logic         ovf2_o
);
  localparam int NPIN = 2;
  localparam int PIN_CNT  = 0;
  localparam int PIN_GATE = 1;

  logic [W-1:0] lo_q, hi_q, lo_nx, hi_nx;
  tmr_mode_e    mode_q;
  logic         ext_q, gate_q, run_q, ovf_q, ovf2_q;
  logic         edge_pend_q;
  logic         ovf_set, ovf2_set;
  logic         inc_lo, inc_hi;
  logic         wr_lo, wr_hi, wr_mode, wr_ctrl;
  logic [NPIN-1:0] pin_raw, pin_lvl, pin_rise;

  assign pin_raw[PIN_CNT]  = cnt_pin_i;
  assign pin_raw[PIN_GATE] = gate_pin_i;

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    timer_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_raw[g]),
      .level_o(pin_lvl[g]),
      .rise_o (pin_rise[g])
    );
  end

  assign wr_lo   = wr_en_i && (wr_addr_i == ADDR_LO);
  assign wr_hi   = wr_en_i && (wr_addr_i == ADDR_HI);
  assign wr_mode = wr_en_i && (wr_addr_i == ADDR_MODE);
  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);

  // edge held until the next tick consumes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  edge_pend_q <= 1'b0;
    else if (wr_mode || tick_i)   edge_pend_q <= 1'b0;
    else if (pin_rise[PIN_CNT])   edge_pend_q <= 1'b1;
  end

  logic src_ok, gate_ok;
  assign src_ok  = !ext_q || edge_pend_q || pin_rise[PIN_CNT];
  assign gate_ok = !gate_q || pin_lvl[PIN_GATE];
  assign inc_lo  = tick_i && run_q && gate_ok && src_ok;
  assign inc_hi  = tick_i && run2_i;

  timer_count_core #(.W(W), .PRE_W(PRE_W)) u_core (
    .mode_i    (mode_q),
    .lo_i      (lo_q),
    .hi_i      (hi_q),
    .inc_lo_i  (inc_lo),
    .inc_hi_i  (inc_hi),
    .lo_o      (lo_nx),
    .hi_o      (hi_nx),
    .ovf_set_o (ovf_set),
    .ovf2_set_o(ovf2_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= wr_lo ? wr_data_i : lo_nx;
      hi_q <= wr_hi ? wr_data_i : hi_nx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_13;
      ext_q  <= 1'b0;
      gate_q <= 1'b0;
    end else if (wr_mode) begin
      mode_q <= tmr_mode_e'(wr_data_i[1:0]);
      ext_q  <= wr_data_i[2];
      gate_q <= wr_data_i[3];
    end
  end

  // hardware set wins over a software clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ovf_q  <= 1'b0;
      ovf2_q <= 1'b0;
    end else if (wr_ctrl) begin
      run_q  <= wr_data_i[0];
      ovf_q  <= wr_data_i[1] | ovf_set;
      ovf2_q <= wr_data_i[2] | ovf2_set;
    end else begin
      ovf_q  <= ovf_q | ovf_set;
      ovf2_q <= ovf2_q | ovf2_set;
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      ADDR_LO:   rd_data_o = lo_q;
      ADDR_HI:   rd_data_o = hi_q;
      ADDR_MODE: rd_data_o = W'({gate_q, ext_q, mode_q});
      default:   rd_data_o = W'({ovf2_q, ovf_q, run_q});
    endcase
  end

  assign ovf_o  = ovf_q;
  assign ovf2_o = ovf2_q;

  assert_mode0_prescale_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_13 && inc_lo && lo_q[PRE_W-1:0] == '1 && !wr_lo) |=> lo_q == '0);

  assert_mode2_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_8R && inc_lo && lo_q == '1 && !wr_lo) |=> lo_q == $past(hi_q));

  assert_split_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SPLIT && tick_i && run2_i && !wr_hi) |=> hi_q == $past(hi_q) + 1'b1);

  assert_no_run_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !wr_lo) |=> $stable(lo_q));

  assert_ext_needs_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_q && !edge_pend_q && !pin_rise[PIN_CNT] && !wr_lo) |=> $stable(lo_q));

  assert_mode_wr_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mode |=> !edge_pend_q);

  assert_ovf_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !wr_ctrl) |=> ovf_q);

  assert_write_prio_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |=> lo_q == $past(wr_data_i));
endmodule

// File: tb/sim_timer_unit.sv
`timescale 1ns/1ps
module sim_timer_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       tick = 1'b0;
  logic       cnt_pin = 1'b0;
  logic       gate_pin = 1'b0;
  logic       run2 = 1'b0;
  logic       ovf, ovf2;
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;

  timer_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .tick_i(tick), .cnt_pin_i(cnt_pin), .gate_pin_i(gate_pin),
    .run2_i(run2), .ovf_o(ovf), .ovf2_o(ovf2)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #0.1;
    d = rd_data;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulse_pin();
    cnt_pin = 1'b1;
    repeat (4) @(negedge clk);
    cnt_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 reg after reset", v, 0);
    end
    chk("R1 ovf_o", ovf, 0);
    chk("R1 ovf2_o", ovf2, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(2'd2, 8'hFF); rd(2'd2, v); chk("R2 mode byte readback", v, 8'h0F);
    wr(2'd0, 8'h5A); rd(2'd0, v); chk("R2 low readback", v, 8'h5A);
    wr(2'd1, 8'hA5); rd(2'd1, v); chk("R2 high readback", v, 8'hA5);
    wr(2'd3, 8'hF8); rd(2'd3, v); chk("R2 ctrl unused bits", v, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_mode1();
    logic [7:0] v;
    wr(2'd2, 8'h01); wr(2'd0, 8'hFE); wr(2'd1, 8'hFF); wr(2'd3, 8'h01);
    ticks(2);
    rd(2'd0, v); chk("R4 low wrapped", v, 8'h00);
    rd(2'd1, v); chk("R4 high wrapped", v, 8'h00);
    chk("R4 overflow set", ovf, 1);
    ticks(3);
    chk("R11 flag held", ovf, 1);
    wr(2'd3, 8'h01);
    chk("R11 flag cleared by ctrl write", ovf, 0);
    wr(2'd0, 8'hFF); wr(2'd1, 8'h12);
    ticks(1);
    rd(2'd1, v); chk("R4 carry into high", v, 8'h13);
  endtask

  task automatic t_mode0();
    logic [7:0] v;
    wr(2'd2, 8'h00); wr(2'd0, 8'h1E); wr(2'd1, 8'hFF);
    ticks(2);
    rd(2'd0, v); chk("R3 low cleared", v, 8'h00);
    rd(2'd1, v); chk("R3 high wrapped", v, 8'h00);
    chk("R3 overflow set", ovf, 1);
    wr(2'd3, 8'h01);
    wr(2'd1, 8'h10);
    ticks(31);
    rd(2'd0, v); chk("R3 prescaler at 0x1F", v, 8'h1F);
    rd(2'd1, v); chk("R3 high not yet", v, 8'h10);
    ticks(1);
    rd(2'd0, v); chk("R3 prescaler cleared", v, 8'h00);
    rd(2'd1, v); chk("R3 high stepped", v, 8'h11);
    chk("R3 no overflow", ovf, 0);
  endtask

  task automatic t_mode2();
    logic [7:0] v;
    wr(2'd2, 8'h02); wr(2'd1, 8'hF0); wr(2'd0, 8'hFE);
    ticks(2);
    rd(2'd0, v); chk("R5 reloaded", v, 8'hF0);
    chk("R5 overflow set", ovf, 1);
    wr(2'd3, 8'h01);
    ticks(15);
    rd(2'd0, v); chk("R5 at 0xFF", v, 8'hFF);
    ticks(1);
    rd(2'd0, v); chk("R5 second reload", v, 8'hF0);
    rd(2'd1, v); chk("R5 high unchanged", v, 8'hF0);
    wr(2'd3, 8'h01);
  endtask

  task automatic t_mode3();
    logic [7:0] v;
    wr(2'd2, 8'h0B); wr(2'd0, 8'hFF); wr(2'd1, 8'hFE); wr(2'd3, 8'h01);
    gate_pin = 1'b0; run2 = 1'b1;
    ticks(3);
    rd(2'd0, v); chk("R8 gated low held", v, 8'hFF);
    rd(2'd1, v); chk("R6 high ignores gate", v, 8'h01);
    chk("R6 ovf2 set", ovf2, 1);
    chk("R6 ovf clear", ovf, 0);
    gate_pin = 1'b1;
    repeat (3) @(negedge clk);
    ticks(1);
    rd(2'd0, v); chk("R8 gate open low wraps", v, 8'h00);
    chk("R6 low wrap sets ovf", ovf, 1);
    run2 = 1'b0;
    ticks(2);
    rd(2'd1, v); chk("R6 high stops without run2", v, 8'h02);
    rd(2'd0, v); chk("R6 low continues", v, 8'h02);
    wr(2'd3, 8'h00);
    run2 = 1'b1;
    ticks(2);
    rd(2'd0, v); chk("R7 low held without run", v, 8'h02);
    rd(2'd1, v); chk("R6 high runs without run bit", v, 8'h04);
    run2 = 1'b0; gate_pin = 1'b0;
    wr(2'd3, 8'h00);
  endtask

  task automatic t_run_gate();
    logic [7:0] v;
    wr(2'd2, 8'h01); wr(2'd0, 8'h10); wr(2'd1, 8'h00);
    ticks(5);
    rd(2'd0, v); chk("R7 stopped mode1", v, 8'h10);
    wr(2'd2, 8'h09); wr(2'd3, 8'h01);
    ticks(4);
    rd(2'd0, v); chk("R8 gate low blocks", v, 8'h10);
    gate_pin = 1'b1;
    repeat (3) @(negedge clk);
    ticks(4);
    rd(2'd0, v); chk("R8 gate high counts", v, 8'h14);
    gate_pin = 1'b0;
  endtask

  task automatic t_ext();
    logic [7:0] v;
    wr(2'd2, 8'h05); wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd3, 8'h01);
    @(negedge clk); tick = 1'b1;
    for (int i = 0; i < 3; i++) pulse_pin();
    tick = 1'b0;
    rd(2'd0, v); chk("R9 one count per edge", v, 8'h03);
    @(negedge clk); tick = 1'b1; cnt_pin = 1'b1;
    @(negedge clk); rd(2'd0, v); chk("R9 not after 1 edge", v, 8'h03);
    @(negedge clk); rd(2'd0, v); chk("R9 not after 2 edges", v, 8'h03);
    @(negedge clk); rd(2'd0, v); chk("R9 counted at 3rd edge", v, 8'h04);
    repeat (4) @(negedge clk);
    cnt_pin = 1'b0; tick = 1'b0;
    repeat (4) @(negedge clk);
    pulse_pin();
    rd(2'd0, v); chk("R9 pending not yet counted", v, 8'h04);
    ticks(1);
    rd(2'd0, v); chk("R9 pending counted", v, 8'h05);
    ticks(3);
    rd(2'd0, v); chk("R9 pending consumed", v, 8'h05);
    pulse_pin(); pulse_pin();
    ticks(3);
    rd(2'd0, v); chk("R9 two edges one count", v, 8'h06);
    pulse_pin();
    wr(2'd2, 8'h05);
    ticks(3);
    rd(2'd0, v); chk("R10 mode write drops edge", v, 8'h06);
  endtask

  task automatic t_prio();
    logic [7:0] v;
    wr(2'd2, 8'h01); wr(2'd0, 8'h20); wr(2'd3, 8'h01);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h40; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    rd(2'd0, v); chk("R12 write beats increment", v, 8'h40);
    ticks(1);
    rd(2'd0, v); chk("R12 counts after write", v, 8'h41);
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h01; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk("R11 set wins over clear", ovf, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_mode1();
    t_mode0();
    t_mode2();
    t_mode3();
    t_run_gate();
    t_ext();
    t_prio();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule